// File: doc/BRIEF.md
# Hex Record Stream Parser

This block consumes a stream of ASCII characters, one per accepted transfer, that holds text lines in the common address-record hex file format. Each line opens with a colon. Pairs of uppercase hex digits follow, and the line ends at the first character whose code is 0x20 or lower. The block turns the digit pairs into bytes and checks each line. It then presents every data byte, paired with its full 32-bit address, on an output stream.

The block keeps the upper 16 address bits, which extended-address lines load. A line's data bytes are held in an internal 256-byte store. None of them leaves the block until that line's checksum and length have passed, so a corrupt line never produces output. The block stops at the first error it finds. It holds a 3-bit error code and the 1-based number of the line that failed until reset. An end-of-file line also stops all further input.

Both streams use valid/ready. A character transfers on a rising edge where `in_valid` and `in_ready` are both high. An output byte transfers on a rising edge where `out_valid` and `out_ready` are both high. `in_ready` is low while a line's bytes are being emitted, after an error and after end of file. While `out_ready` is low, `out_valid`, `out_addr` and `out_data` hold their values. `out_ready` may change freely.

Top module: `hexrec_parser`

## Requirements
- R1: The first character of every line must be a colon (0x3A). Any other first character raises error code 1.
- R2: Inside a line, only 0x30-0x39 and 0x41-0x46 are digits. Any other character above 0x20 raises error code 2. A line that ends with an odd number of digits also raises error code 2.
- R3: A line that ends after fewer than 5 decoded bytes raises error code 3.
- R4: Let S be the 8-bit sum of every decoded byte except the last. The checksum passes only when S is nonzero and S plus the last byte is 0 modulo 256. Otherwise the line raises error code 4.
- R5: For a record of type 0x00, the number of decoded bytes must equal the first byte (length) plus 5. For type 0x04, the line must hold at least 7 bytes. Otherwise the line raises error code 5.
- R6: A valid type 0x00 record emits its data bytes in order. The first data byte is byte 4 of the line. Byte i gets the address ({upper, record address} + i) modulo 2^32, where the record address is bytes 1 (high) and 2 (low). No byte of a line is emitted before its terminator is accepted.
- R7: A valid type 0x04 record sets the upper 16 address bits to {byte 4, byte 5}. Until such a record arrives, the upper bits are 0.
- R8: A valid type 0x01 record raises `done`. After that, `in_ready` and `out_valid` stay low until reset.
- R9: A checksum-valid record of any type other than 0x00, 0x01 or 0x04 raises error code 6.
- R10: The first error raises `err_valid`, and `err_code` and `err_line` stay frozen until reset. `err_line` is the 1-based number of the failing line, counting only complete valid lines before it. After an error, `in_ready` and `out_valid` stay low.
- R11: `in_ready` is low while `out_valid` is high. Under back-pressure, the output address and data hold.
- R12: After reset, `in_ready` is 1 and `out_valid`, `err_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Character available |
| in_ready | output | 1 | Block accepts a character |
| in_char | input | 8 | ASCII character |
| out_valid | output | 1 | Data byte available |
| out_ready | input | 1 | Consumer accepts a byte |
| out_addr | output | 32 | Address of the presented byte |
| out_data | output | 8 | Presented data byte |
| err_valid | output | 1 | Sticky error flag |
| err_code | output | 3 | Error code, 1 to 6 (see R1-R5, R9) |
| err_line | output | LINE_W | Line number of the failing line |
| done | output | 1 | End-of-file record accepted |

## Verification
An error flag and its code appear in the cycle after the edge that accepts the offending character, either a wrong lead character, a bad digit or the terminator. A record's first output byte is presented in that same cycle after the terminator is accepted, and each further byte follows the edge that completes the previous handshake. The bench drives inputs and samples outputs on falling edges. It checks the error ports right after the accepting edge. It updates `out_ready` on a falling edge, then compares the presented byte with the expected one for the handshake that happens on the next rising edge.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_LEAD  = 3'd1,
    FLT_DIGIT = 3'd2,
    FLT_SHORT = 3'd3,
    FLT_SUM   = 3'd4,
    FLT_SIZE  = 3'd5,
    FLT_KIND  = 3'd6
  } hexrec_fault_e;

  typedef enum logic [2:0] {
    PS_LEAD,
    PS_BODY,
    PS_EMIT,
    PS_FAULT,
    PS_END
  } hexrec_state_e;

  localparam logic [7:0] KIND_DATA  = 8'h00;
  localparam logic [7:0] KIND_END   = 8'h01;
  localparam logic [7:0] KIND_UPPER = 8'h04;

  localparam logic [7:0] CH_COLON = 8'h3A;
  localparam logic [7:0] CH_BLANK = 8'h20;

  localparam int HEAD_BYTES  = 4;
  localparam int MIN_BYTES   = 5;
  localparam int UPPER_BYTES = 7;
  localparam int FIELD_SLOTS = 6;

endpackage

// File: rtl/hexrec_nibble.sv
module hexrec_nibble
  import hexrec_pkg::*;
(
  input  logic [7:0] ch,
  output logic       is_digit,
  output logic       is_term,
  output logic [3:0] value
);

  always_comb begin
    is_term  = (ch <= CH_BLANK);
    is_digit = 1'b0;
    value    = 4'd0;
    if (ch >= 8'h30 && ch <= 8'h39) begin
      is_digit = 1'b1;
      value    = ch[3:0];
    end else if (ch >= 8'h41 && ch <= 8'h46) begin
      is_digit = 1'b1;
      value    = ch[3:0] + 4'd9;
    end
  end

endmodule

// File: rtl/hexrec_line.sv
module hexrec_line
  import hexrec_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = LEN_W + 2,
  parameter int DEPTH = 1 << LEN_W,
  parameter int IDX_W = LEN_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        nib_en,
  input  logic [3:0]                  nib,
  output logic                        half,
  output logic [CNT_W-1:0]            cnt,
  output logic [7:0]                  sum_all,
  output logic [7:0]                  sum_head,
  output logic [FIELD_SLOTS-1:0][7:0] fields,
  output logic                        wr_en,
  output logic [IDX_W-1:0]            wr_idx,
  output logic [7:0]                  wr_byte
);

  logic [3:0]       hi_q;
  logic [7:0]       byte_now;
  logic             byte_done;
  logic [CNT_W-1:0] off;

  assign byte_now  = {hi_q, nib};
  assign byte_done = nib_en && half;
  assign off       = cnt - CNT_W'(HEAD_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half     <= 1'b0;
      hi_q     <= 4'd0;
      cnt      <= '0;
      sum_all  <= 8'd0;
      sum_head <= 8'd0;
    end else if (start) begin
      half     <= 1'b0;
      cnt      <= '0;
      sum_all  <= 8'd0;
      sum_head <= 8'd0;
    end else if (nib_en) begin
      if (!half) begin
        hi_q <= nib;
        half <= 1'b1;
      end else begin
        half     <= 1'b0;
        cnt      <= (cnt == '1) ? cnt : cnt + 1'b1;
        sum_head <= sum_all;
        sum_all  <= sum_all + byte_now;
      end
    end
  end

  for (genvar g = 0; g < FIELD_SLOTS; g++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fields[g] <= 8'd0;
      else if (byte_done && cnt == CNT_W'(g)) fields[g] <= byte_now;
    end
  end

  assign wr_en   = byte_done && (cnt >= CNT_W'(HEAD_BYTES)) && (off < CNT_W'(DEPTH));
  assign wr_idx  = off[IDX_W-1:0];
  assign wr_byte = byte_now;

endmodule

// File: rtl/hexrec_store.sv
module hexrec_store #(
  parameter int DEPTH = 256,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_byte;
  end

  assign rd_byte = mem[rd_idx];

endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
  import hexrec_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_char,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_addr,
  output logic [7:0]        out_data,
  output logic              err_valid,
  output logic [2:0]        err_code,
  output logic [LINE_W-1:0] err_line,
  output logic              done
);

  localparam int DEPTH = 1 << LEN_W;
  localparam int IDX_W = LEN_W;
  localparam int CNT_W = LEN_W + 2;

  hexrec_state_e st;
  hexrec_fault_e fault_q, verdict;

  logic              take, is_digit, is_term;
  logic [3:0]        nib;
  logic              line_start, nib_en;
  logic              half;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        sum_all, sum_head;
  logic [FIELD_SLOTS-1:0][7:0] fields;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [7:0]        wr_byte, rd_byte;

  logic [LINE_W-1:0] line_no;
  logic [15:0]       upper;
  logic [31:0]       base;
  logic [LEN_W-1:0]  emit_idx, emit_last;

  assign in_ready   = (st == PS_LEAD) || (st == PS_BODY);
  assign take       = in_valid && in_ready;
  assign line_start = take && (st == PS_LEAD) && (in_char == CH_COLON);
  assign nib_en     = take && (st == PS_BODY) && is_digit;

  hexrec_nibble u_nibble (
    .ch       (in_char),
    .is_digit (is_digit),
    .is_term  (is_term),
    .value    (nib)
  );

  hexrec_line #(
    .LEN_W (LEN_W),
    .CNT_W (CNT_W),
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (line_start),
    .nib_en   (nib_en),
    .nib      (nib),
    .half     (half),
    .cnt      (cnt),
    .sum_all  (sum_all),
    .sum_head (sum_head),
    .fields   (fields),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_byte  (wr_byte)
  );

  hexrec_store #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_byte (wr_byte),
    .rd_idx  (emit_idx[IDX_W-1:0]),
    .rd_byte (rd_byte)
  );

  // Judgement of a completed line, valid in the cycle its terminator is offered.
  always_comb begin
    verdict = FLT_NONE;
    if (half) begin
      verdict = FLT_DIGIT;
    end else if (cnt < CNT_W'(MIN_BYTES)) begin
      verdict = FLT_SHORT;
    end else if (!(sum_all == 8'd0 && sum_head != 8'd0)) begin
      verdict = FLT_SUM;
    end else begin
      case (fields[3])
        KIND_DATA:  if (cnt != CNT_W'(fields[0]) + CNT_W'(MIN_BYTES)) verdict = FLT_SIZE;
        KIND_END:   verdict = FLT_NONE;
        KIND_UPPER: if (cnt < CNT_W'(UPPER_BYTES)) verdict = FLT_SIZE;
        default:    verdict = FLT_KIND;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PS_LEAD;
      fault_q   <= FLT_NONE;
      err_line  <= '0;
      line_no   <= LINE_W'(1);
      upper     <= 16'd0;
      base      <= 32'd0;
      emit_idx  <= '0;
      emit_last <= '0;
    end else begin
      case (st)
        PS_LEAD: begin
          if (take) begin
            if (in_char == CH_COLON) begin
              st <= PS_BODY;
            end else begin
              st       <= PS_FAULT;
              fault_q  <= FLT_LEAD;
              err_line <= line_no;
            end
          end
        end
        PS_BODY: begin
          if (take && !is_digit) begin
            if (!is_term) begin
              st       <= PS_FAULT;
              fault_q  <= FLT_DIGIT;
              err_line <= line_no;
            end else if (verdict != FLT_NONE) begin
              st       <= PS_FAULT;
              fault_q  <= verdict;
              err_line <= line_no;
            end else begin
              line_no <= line_no + 1'b1;
              case (fields[3])
                KIND_DATA: begin
                  base      <= {upper, fields[1], fields[2]};
                  emit_idx  <= '0;
                  emit_last <= fields[0][LEN_W-1:0] - 1'b1;
                  st        <= (fields[0] == 8'd0) ? PS_LEAD : PS_EMIT;
                end
                KIND_UPPER: begin
                  upper <= {fields[4], fields[5]};
                  st    <= PS_LEAD;
                end
                default: st <= PS_END;
              endcase
            end
          end
        end
        PS_EMIT: begin
          if (out_ready) begin
            if (emit_idx == emit_last) st <= PS_LEAD;
            else emit_idx <= emit_idx + 1'b1;
          end
        end
        default: st <= st;
      endcase
    end
  end

  assign out_valid = (st == PS_EMIT);
  assign out_addr  = base + 32'(emit_idx);
  assign out_data  = rd_byte;
  assign err_valid = (st == PS_FAULT);
  assign err_code  = fault_q;
  assign done      = (st == PS_END);

endmodule

// File: rtl/hexrec_parser_chk.sv
module hexrec_parser_chk #(
  parameter int LINE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [31:0]       out_addr,
  input logic [7:0]        out_data,
  input logic              err_valid,
  input logic [2:0]        err_code,
  input logic [LINE_W-1:0] err_line,
  input logic              done
);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> err_valid && $stable(err_code) && $stable(err_line));

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> !in_ready && !out_valid && err_code != 3'd0);

  assert_end_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !in_ready && !out_valid);

  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data));

  assert_in_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid || out_addr == $past(out_addr) + 32'd1);

  assert_in_known_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> !err_valid && !done);

endmodule

bind hexrec_parser hexrec_parser_chk #(.LINE_W(LINE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_data  (out_data),
  .err_valid (err_valid),
  .err_code  (err_code),
  .err_line  (err_line),
  .done      (done)
);

// File: tb/hexrec_parser_test.sv
module hexrec_parser_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_char = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic [7:0]  out_data;
  logic        err_valid;
  logic [2:0]  err_code;
  logic [15:0] err_line;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_a[$];
  logic [7:0]  exp_d[$];
  logic [7:0]  rawb [0:263];
  logic [15:0] upper_m;
  int          lines_m;
  bit          bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  hexrec_parser uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_char   (in_char),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_data  (out_data),
    .err_valid (err_valid),
    .err_code  (err_code),
    .err_line  (err_line),
    .done      (done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Consumer: set ready for the coming edge, then score the handshake it will complete.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_mode ? lfsr[0] : 1'b1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_a.size() == 0) begin
        chk(1'b0, "R6 unexpected output byte", out_addr, 32'h0);
      end else begin
        chk(out_addr == exp_a[0], "R6 address", out_addr, exp_a[0]);
        chk(out_data == exp_d[0], "R6 data", {24'h0, out_data}, {24'h0, exp_d[0]});
        void'(exp_a.pop_front());
        void'(exp_d.pop_front());
      end
      chk(!in_ready, "R11 input stalled while emitting", {31'h0, in_ready}, 32'h0);
    end
  end

  function automatic logic [7:0] hexch(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + {4'h0, n} : 8'h37 + {4'h0, n};
  endfunction

  function automatic logic [7:0] frame_ck(input int n);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < n; i++) s = s + rawb[i];
    return 8'h00 - s;
  endfunction

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
    while (!in_ready && !err_valid && !done) @(negedge clk);
    if (in_ready) @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_hex(input logic [7:0] b);
    send_char(hexch(b[7:4]));
    send_char(hexch(b[3:0]));
  endtask

  task automatic send_frame(input int n, input logic [7:0] ck);
    send_char(8'h3A);
    for (int i = 0; i < n; i++) send_hex(rawb[i]);
    send_hex(ck);
    send_char(8'h0A);
  endtask

  // Builds a well-formed record from rawb[4..] and queues its expected output.
  task automatic send_rec(input logic [7:0] typ, input logic [15:0] addr, input int n);
    rawb[0] = 8'(n);
    rawb[1] = addr[15:8];
    rawb[2] = addr[7:0];
    rawb[3] = typ;
    if (frame_ck(n + 4) == 8'h00 && n > 0) rawb[4] = rawb[4] + 8'h01;
    if (typ == 8'h00)
      for (int i = 0; i < n; i++) begin
        exp_a.push_back({upper_m, addr} + 32'(i));
        exp_d.push_back(rawb[4 + i]);
      end
    if (typ == 8'h04) upper_m = {rawb[4], rawb[5]};
    lines_m++;
    send_frame(n + 4, frame_ck(n + 4));
  endtask

  task automatic wait_drain(input string req);
    while (exp_a.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(!out_valid, req, {31'h0, out_valid}, 32'h0);
  endtask

  task automatic do_reset;
    in_valid = 1'b0;
    rst_n    = 1'b0;
    bp_mode  = 1'b0;
    exp_a.delete();
    exp_d.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    upper_m = 16'h0000;
    lines_m = 1;
  endtask

  task automatic expect_err(input logic [2:0] code, input int line, input string req);
    chk(err_valid, req, {31'h0, err_valid}, 32'h1);
    chk(err_code == code, req, {29'h0, err_code}, {29'h0, code});
    chk(err_line == 16'(line), req, {16'h0, err_line}, 32'(line));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    // R12: reset state
    chk(in_ready, "R12 in_ready", {31'h0, in_ready}, 32'h1);
    chk(!out_valid && !err_valid && !done, "R12 outputs idle",
        {29'h0, out_valid, err_valid, done}, 32'h0);

    // R6: data records of several sizes, with and without back-pressure
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: n = 1;  1: n = 2;  2: n = 16;
        3: n = 0;  4: n = 255; default: n = 7;
      endcase
      bp_mode = k[0];
      for (int i = 0; i < n; i++) rawb[4 + i] = 8'(i * 37 + k * 11 + 3);
      send_rec(8'h00, 16'h0100 * 16'(k) + 16'h0033, n);
      wait_drain("R6 record drained");
    end
    chk(!err_valid, "R6 no error on valid data", {31'h0, err_valid}, 32'h0);

    // R7: upper address loads, including 32-bit wrap
    rawb[4] = 8'h12; rawb[5] = 8'h34;
    send_rec(8'h04, 16'h0000, 2);
    for (int i = 0; i < 3; i++) rawb[4 + i] = 8'hA0 + 8'(i);
    send_rec(8'h00, 16'h8000, 3);
    wait_drain("R7 upper applied");
    rawb[4] = 8'hFF; rawb[5] = 8'hFF;
    send_rec(8'h04, 16'h0000, 2);
    bp_mode = 1'b1;
    for (int i = 0; i < 4; i++) rawb[4 + i] = 8'h50 + 8'(i);
    send_rec(8'h00, 16'hFFFE, 4);
    wait_drain("R7 wrap drained");
    chk(!err_valid, "R7 no error", {31'h0, err_valid}, 32'h0);

    // R1 / R10: bad lead character with line number, then sticky
    send_char(8'h51);
    expect_err(3'd1, lines_m, "R1 bad lead char");
    @(negedge clk);
    in_valid = 1'b1; in_char = 8'h3A;
    repeat (8) @(negedge clk);
    chk(!in_ready && !out_valid, "R10 frozen input", {30'h0, in_ready, out_valid}, 32'h0);
    in_valid = 1'b0;
    expect_err(3'd1, lines_m, "R10 error sticky");

    // R8: end-of-file record
    do_reset();
    rawb[4] = 8'h11; rawb[5] = 8'h22;
    send_rec(8'h00, 16'h0040, 2);
    wait_drain("R8 data before end");
    send_rec(8'h01, 16'h0000, 0);
    chk(done && !in_ready, "R8 done set", {30'h0, done, in_ready}, 32'h2);
    @(negedge clk);
    in_valid = 1'b1; in_char = 8'h3A;
    repeat (8) @(negedge clk);
    in_valid = 1'b0;
    chk(done && !in_ready && !out_valid && !err_valid, "R8 input ignored after end",
        {28'h0, done, in_ready, out_valid, err_valid}, 32'h8);

    // R2 / R3: sweep of every second character
    for (int c = 0; c < 256; c++) begin
      do_reset();
      send_char(8'h3A);
      send_char(8'(c));
      if ((c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46))
        chk(!err_valid, "R2 digit accepted", {31'h0, err_valid}, 32'h0);
      else if (c <= 8'h20)
        expect_err(3'd3, 1, "R3 empty line short");
      else
        expect_err(3'd2, 1, "R2 non-digit");
    end

    // R2: odd digit count
    do_reset();
    send_char(8'h3A); send_char(8'h30); send_char(8'h0A);
    expect_err(3'd2, 1, "R2 odd digits");

    // R3: four bytes only
    do_reset();
    send_char(8'h3A);
    for (int i = 0; i < 4; i++) send_hex(8'h00);
    send_char(8'h0A);
    expect_err(3'd3, 1, "R3 four bytes");

    // R4: checksum sweep
    for (int cc = 0; cc < 256; cc++) begin
      do_reset();
      rawb[0] = 8'h01; rawb[1] = 8'h00; rawb[2] = 8'h10; rawb[3] = 8'h00; rawb[4] = 8'h5A;
      if (cc == 8'h95) begin
        exp_a.push_back(32'h0000_0010);
        exp_d.push_back(8'h5A);
      end
      send_frame(5, 8'(cc));
      if (cc == 8'h95) begin
        wait_drain("R4 good checksum drained");
        chk(!err_valid, "R4 good checksum", {31'h0, err_valid}, 32'h0);
      end else begin
        expect_err(3'd4, 1, "R4 bad checksum");
        chk(!out_valid, "R4 nothing emitted", {31'h0, out_valid}, 32'h0);
      end
    end

    // R4: zero sum is rejected
    do_reset();
    for (int i = 0; i < 4; i++) rawb[i] = 8'h00;
    send_frame(4, 8'h00);
    expect_err(3'd4, 1, "R4 zero sum");

    // R5: data length mismatch
    do_reset();
    rawb[0] = 8'h02; rawb[1] = 8'h00; rawb[2] = 8'h00; rawb[3] = 8'h00;
    rawb[4] = 8'hAA; rawb[5] = 8'hBB; rawb[6] = 8'hCC;
    send_frame(7, frame_ck(7));
    expect_err(3'd5, 1, "R5 data length mismatch");

    // R5: upper record missing a byte
    do_reset();
    rawb[0] = 8'h01; rawb[1] = 8'h00; rawb[2] = 8'h00; rawb[3] = 8'h04; rawb[4] = 8'h12;
    send_frame(5, frame_ck(5));
    expect_err(3'd5, 1, "R5 short upper record");

    // R9: sweep of all record types with an empty body
    for (int t = 0; t < 256; t++) begin
      do_reset();
      rawb[0] = 8'h00; rawb[1] = 8'h01; rawb[2] = 8'h00; rawb[3] = 8'(t);
      send_frame(4, frame_ck(4));
      if (((1 + t) & 255) == 0)      expect_err(3'd4, 1, "R4 type sweep zero sum");
      else if (t == 0)               chk(!err_valid && in_ready, "R6 empty data record",
                                         {30'h0, err_valid, in_ready}, 32'h1);
      else if (t == 1)               chk(done, "R8 end record", {31'h0, done}, 32'h1);
      else if (t == 4)               expect_err(3'd5, 1, "R5 empty upper record");
      else                           expect_err(3'd6, 1, "R9 unknown type");
    end

    // R10: line number after several good lines
    do_reset();
    for (int j = 0; j < 3; j++) begin
      rawb[4] = 8'(j + 1);
      send_rec(8'h00, 16'(j), 1);
    end
    wait_drain("R10 lines drained");
    send_char(8'h3A); send_char(8'h67);
    expect_err(3'd2, 4, "R10 line number");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule